// File: doc/BRIEF.md
# Common-Mode Noise Subtraction Unit

This block takes one readout frame of 128 raw strip samples at a time and returns the same 128 strips with two things removed. The first is each strip's own stored pedestal. The second is the offset that all strips share, called the common mode. Raw samples arrive as 10-bit unsigned ADC codes on a valid/ready stream. Corrected values leave as signed 11-bit numbers on a second valid/ready stream, in strip order.

A pedestal table holds one signed 11-bit value per strip. It is filled through a single-cycle write port, which may be used at any time.

The common mode can be estimated in three ways:

- **Grouped mean:** a separate mean for each of the four 32-strip groups.
- **Truncated mean:** a mean over the whole chip that ignores the extreme values at both ends.
- **Median:** the lower median over the whole chip.

The frame is held internally. The estimate is formed once all 128 strips are in, and only then does output begin.

Top module: `cmn_sub`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: Each accepted sample becomes a pedestal-subtracted value d = raw − ped[strip]. The result is clamped to the range −1024..1023. Pedestals are written with `ped_we`/`ped_addr`/`ped_data` and are signed.
- R3: With mode code 0 (grouped mean), the strips form groups 0–31, 32–63, 64–95 and 96–127. Each group's common mode is the sum of its 32 d values divided by 32, truncated toward zero.
- R4: With mode code 1 (truncated mean), the d values are ranked. The 13 smallest and the 13 largest are discarded. The common mode is the sum of the remaining 102 values divided by 102, truncated toward zero.
- R5: With mode code 2 or 3 (median), the common mode is the 64th smallest d value (rank 63 counted from 0 in ascending order).
- R6: Each output value is d minus the common mode that applies to its strip, clamped to −1024..1023.
- R7: The mode is taken from `cfg_mode` on the first accepted sample of a frame. Later changes of `cfg_mode` during that frame have no effect on it.
- R8: Outputs are given for strips 0 to 127 in order, and `out_last` is set on strip 127. While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_last` hold steady and no value is lost.
- R9: `in_ready` drops after the 128th accepted sample and returns only after the last output has been accepted. `in_ready` and `out_valid` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | Estimator select: 0 grouped, 1 truncated, 2/3 median |
| ped_we | input | 1 | Pedestal write enable |
| ped_addr | input | 7 | Strip index to write |
| ped_data | input | 11 | Signed pedestal value |
| in_valid | input | 1 | Raw sample valid |
| in_ready | output | 1 | Block accepts a raw sample |
| in_data | input | 10 | Raw unsigned ADC sample |
| out_valid | output | 1 | Corrected sample valid |
| out_ready | input | 1 | Consumer accepts a corrected sample |
| out_data | output | 11 | Signed corrected sample |
| out_last | output | 1 | Marks strip 127 of the frame |

## Verification
The hardest behaviour to reach from the ports is the ranking in truncated-mean mode. Only a few outliers decide whether the discard window lands exactly 13 places from each end. To exercise it, the stimulus plants strong high and low outliers inside an otherwise narrow spread of values, and it drains the result under irregular backpressure.

Clamping is reached by writing large negative and positive pedestals against full-scale and zero raw codes, so that both the pedestal step and the final subtraction go past the range. A mid-frame mode change checks that the mode latched on the first sample holds for the rest of the frame.

// File: rtl/cmn_pkg.sv
package cmn_pkg;

    typedef enum logic [1:0] {
        CM_GROUP      = 2'd0,
        CM_TRUNC      = 2'd1,
        CM_MEDIAN     = 2'd2,
        CM_MEDIAN_ALT = 2'd3
    } cm_mode_e;

    typedef enum logic [1:0] {
        PH_FILL,
        PH_RANK,
        PH_CALC,
        PH_EMIT
    } phase_e;

    // share of strips dropped at each end in truncated mode, in percent
    localparam int TRIM_PERCENT = 10;

endpackage

// File: rtl/cmn_ped_mem.sv
module cmn_ped_mem #(
    parameter int DEPTH = 128,
    parameter int W     = 11,
    localparam int AW   = $clog2(DEPTH)
)(
    input  logic                clk,
    input  logic                we,
    input  logic [AW-1:0]       waddr,
    input  logic signed [W-1:0] wdata,
    input  logic [AW-1:0]       raddr,
    output logic signed [W-1:0] rdata
);
    logic signed [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/cmn_rank.sv
// Position of element sel in the ascending order of vals.
// Ties are broken by index, so the ranks form a permutation.
module cmn_rank #(
    parameter int N  = 128,
    parameter int W  = 11,
    localparam int IW = $clog2(N)
)(
    input  logic signed [W-1:0] vals [N],
    input  logic [IW-1:0]       sel,
    output logic [IW-1:0]       rank
);
    logic [IW:0]         tally;
    logic signed [W-1:0] pivot;

    assign pivot = vals[sel];

    always_comb begin
        tally = '0;
        for (int j = 0; j < N; j++) begin
            if ((vals[j] < pivot) || ((vals[j] == pivot) && (IW'(j) < sel)))
                tally = tally + 1'b1;
        end
    end

    assign rank = tally[IW-1:0];
endmodule

// File: rtl/cmn_sub.sv
module cmn_sub
    import cmn_pkg::*;
#(
    parameter int N_STRIPS = 128,
    parameter int N_GROUPS = 4,
    parameter int ADC_W    = 10,
    parameter int VAL_W    = 11,
    localparam int IDX_W   = $clog2(N_STRIPS)
)(
    input  logic                    clk,
    input  logic                    rst,
    input  logic [1:0]              cfg_mode,
    input  logic                    ped_we,
    input  logic [IDX_W-1:0]        ped_addr,
    input  logic signed [VAL_W-1:0] ped_data,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [ADC_W-1:0]        in_data,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic signed [VAL_W-1:0] out_data,
    output logic                    out_last
);
    localparam int GROUP_SZ = N_STRIPS / N_GROUPS;
    localparam int GRP_W    = $clog2(N_GROUPS);
    localparam int TRIM     = (N_STRIPS * TRIM_PERCENT + 99) / 100;
    localparam int KEEP     = N_STRIPS - 2 * TRIM;
    localparam int SUM_W    = VAL_W + IDX_W + 1;

    typedef logic signed [VAL_W-1:0] val_t;
    typedef logic signed [SUM_W-1:0] sum_t;

    localparam sum_t S_MAX = SUM_W'((1 << (VAL_W - 1)) - 1);
    localparam sum_t S_MIN = SUM_W'(-(1 << (VAL_W - 1)));
    localparam logic [IDX_W-1:0] LAST  = IDX_W'(N_STRIPS - 1);
    localparam logic [IDX_W-1:0] R_LO  = IDX_W'(TRIM);
    localparam logic [IDX_W-1:0] R_HI  = IDX_W'(N_STRIPS - TRIM);
    localparam logic [IDX_W-1:0] R_MED = IDX_W'(N_STRIPS / 2 - 1);

    function automatic val_t clip(input sum_t x);
        if (x > S_MAX) return VAL_W'(S_MAX);
        if (x < S_MIN) return VAL_W'(S_MIN);
        return VAL_W'(x);
    endfunction

    phase_e           st;
    logic [IDX_W-1:0] cnt;
    cm_mode_e         mode_q;
    val_t             frame_q [N_STRIPS];
    sum_t             gsum [N_GROUPS];
    val_t             gcm [N_GROUPS];
    sum_t             tsum;
    val_t             med_q;
    val_t             ccm;

    val_t             ped_rd;
    sum_t             diff_x;
    val_t             diff_v;
    logic [IDX_W-1:0] rank;
    logic [GRP_W-1:0] grp;
    logic             in_fire;
    logic             out_fire;
    val_t             cm_sel;
    logic [IDX_W-1:0] cnt_nx;

    cmn_ped_mem #(.DEPTH(N_STRIPS), .W(VAL_W)) u_ped (
        .clk   (clk),
        .we    (ped_we),
        .waddr (ped_addr),
        .wdata (ped_data),
        .raddr (cnt),
        .rdata (ped_rd)
    );

    cmn_rank #(.N(N_STRIPS), .W(VAL_W)) u_rank (
        .vals (frame_q),
        .sel  (cnt),
        .rank (rank)
    );

    assign in_ready  = (st == PH_FILL);
    assign out_valid = (st == PH_EMIT);
    assign in_fire   = in_valid && in_ready;
    assign out_fire  = out_valid && out_ready;
    assign grp       = cnt[IDX_W-1 -: GRP_W];
    assign cnt_nx    = (cnt == LAST) ? '0 : cnt + 1'b1;

    assign diff_x = $signed(SUM_W'({1'b0, in_data})) - sum_t'(ped_rd);
    assign diff_v = clip(diff_x);

    assign cm_sel   = (mode_q == CM_GROUP) ? gcm[grp] : ccm;
    assign out_data = clip(sum_t'(frame_q[cnt]) - sum_t'(cm_sel));
    assign out_last = out_valid && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= PH_FILL;
            cnt    <= '0;
            mode_q <= CM_GROUP;
            tsum   <= '0;
            med_q  <= '0;
            ccm    <= '0;
            for (int g = 0; g < N_GROUPS; g++) begin
                gsum[g] <= '0;
                gcm[g]  <= '0;
            end
        end else begin
            case (st)
                PH_FILL: if (in_fire) begin
                    frame_q[cnt] <= diff_v;
                    gsum[grp]    <= gsum[grp] + sum_t'(diff_v);
                    if (cnt == '0) mode_q <= cm_mode_e'(cfg_mode);
                    cnt <= cnt_nx;
                    if (cnt == LAST) st <= PH_RANK;
                end
                PH_RANK: begin
                    if (rank >= R_LO && rank < R_HI)
                        tsum <= tsum + sum_t'(frame_q[cnt]);
                    if (rank == R_MED) med_q <= frame_q[cnt];
                    cnt <= cnt_nx;
                    if (cnt == LAST) st <= PH_CALC;
                end
                PH_CALC: begin
                    for (int g = 0; g < N_GROUPS; g++)
                        gcm[g] <= VAL_W'(gsum[g] / sum_t'(GROUP_SZ));
                    ccm <= (mode_q == CM_TRUNC) ? VAL_W'(tsum / sum_t'(KEEP)) : med_q;
                    st  <= PH_EMIT;
                end
                PH_EMIT: if (out_fire) begin
                    cnt <= cnt_nx;
                    if (cnt == LAST) begin
                        st   <= PH_FILL;
                        tsum <= '0;
                        for (int g = 0; g < N_GROUPS; g++) gsum[g] <= '0;
                    end
                end
                default: st <= PH_FILL;
            endcase
        end
    end
endmodule

// File: rtl/cmn_sub_chk.sv
module cmn_sub_chk #(
    parameter int N_STRIPS = 128,
    parameter int VAL_W    = 11,
    localparam int CW      = $clog2(N_STRIPS) + 1
)(
    input logic                    clk,
    input logic                    rst,
    input logic                    in_valid,
    input logic                    in_ready,
    input logic                    out_valid,
    input logic                    out_ready,
    input logic signed [VAL_W-1:0] out_data,
    input logic                    out_last
);
    logic [CW-1:0] in_cnt;
    logic [CW-1:0] out_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_cnt  <= '0;
            out_cnt <= '0;
        end else begin
            if (in_valid && in_ready) in_cnt <= in_cnt + 1'b1;
            if (out_valid && out_ready) begin
                if (out_last) begin
                    out_cnt <= '0;
                    in_cnt  <= '0;
                end else begin
                    out_cnt <= out_cnt + 1'b1;
                end
            end
        end
    end

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

    p_last_pos_r8: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_last == (out_cnt == CW'(N_STRIPS - 1))));

    p_no_overlap_r9: assert property (@(posedge clk) disable iff (rst)
        !(in_ready && out_valid));

    p_frame_full_r9: assert property (@(posedge clk) disable iff (rst)
        (in_cnt == CW'(N_STRIPS)) |-> !in_ready);

    p_out_after_fill_r9: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (in_cnt == CW'(N_STRIPS)));
endmodule

bind cmn_sub cmn_sub_chk #(.N_STRIPS(N_STRIPS), .VAL_W(VAL_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last)
);

// File: tb/cmn_sub_tb.sv
module cmn_sub_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N = 128;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [1:0]        cfg_mode = 2'd0;
    logic              ped_we = 1'b0;
    logic [6:0]        ped_addr = '0;
    logic signed [10:0] ped_data = '0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [9:0]        in_data = '0;
    logic              out_valid;
    logic              out_ready = 1'b0;
    logic signed [10:0] out_data;
    logic              out_last;

    int n_checks = 0;
    int n_fail   = 0;
    int raw  [N];
    int ped  [N];
    int expv [N];

    always #(CLK_PERIOD / 2) clk = ~clk;

    cmn_sub u_dut (
        .clk(clk), .rst(rst), .cfg_mode(cfg_mode),
        .ped_we(ped_we), .ped_addr(ped_addr), .ped_data(ped_data),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_last(out_last)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int sat(input int x);
        if (x > 1023) return 1023;
        if (x < -1024) return -1024;
        return x;
    endfunction

    // reference model built from the requirements
    task automatic model(input int mode);
        int d [N];
        int s [N];
        int cm [4];
        for (int i = 0; i < N; i++) begin
            d[i] = sat(raw[i] - ped[i]);
            s[i] = d[i];
        end
        for (int a = 0; a < N - 1; a++)
            for (int b = 0; b < N - 1 - a; b++)
                if (s[b] > s[b + 1]) begin
                    int t = s[b]; s[b] = s[b + 1]; s[b + 1] = t;
                end
        if (mode == 0) begin
            for (int g = 0; g < 4; g++) begin
                int acc = 0;
                for (int k = 0; k < 32; k++) acc += d[g * 32 + k];
                cm[g] = acc / 32;
            end
        end else if (mode == 1) begin
            int acc = 0;
            for (int k = 13; k < N - 13; k++) acc += s[k];
            for (int g = 0; g < 4; g++) cm[g] = acc / 102;
        end else begin
            for (int g = 0; g < 4; g++) cm[g] = s[63];
        end
        for (int i = 0; i < N; i++) expv[i] = sat(d[i] - cm[i / 32]);
    endtask

    task automatic load_peds();
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            ped_we = 1'b1; ped_addr = 7'(i); ped_data = 11'(ped[i]);
        end
        @(negedge clk);
        ped_we = 1'b0;
    endtask

    // send one frame, then drain and compare every strip
    task automatic run_frame(input string req, input int mode_first, input int mode_rest, input bit bp);
        int k = 0;
        int cyc = 0;
        bit held = 0;
        int held_d = 0;
        int held_l = 0;
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            while (!in_ready) @(negedge clk);
            cfg_mode = 2'((i == 0) ? mode_first : mode_rest);
            in_valid = 1'b1;
            in_data  = 10'(raw[i]);
        end
        @(negedge clk);
        in_valid = 1'b0;
        check("R9", "in_ready after full frame", int'(in_ready), 0);
        while (k < N && cyc < 2000) begin
            @(negedge clk);
            cyc++;
            if (held) begin
                check("R8", "valid held under backpressure", int'(out_valid), 1);
                check("R8", "data held under backpressure", int'(out_data), held_d);
                check("R8", "last held under backpressure", int'(out_last), held_l);
            end
            out_ready = bp ? ((cyc % 3) != 0) : 1'b1;
            held = 0;
            if (out_valid) begin
                if (in_ready) check("R9", "in_ready during output", 1, 0);
                if (out_ready) begin
                    check(req, $sformatf("strip %0d value", k), int'(out_data), expv[k]);
                    check("R8", $sformatf("strip %0d last flag", k), int'(out_last), (k == N - 1) ? 1 : 0);
                    k++;
                end else begin
                    held = 1; held_d = int'(out_data); held_l = int'(out_last);
                end
            end
        end
        check(req, "strips received", k, N);
        @(negedge clk);
        out_ready = 1'b0;
        check("R9", "in_ready back after frame", int'(in_ready), 1);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "in_ready after reset", int'(in_ready), 1);
        check("R1", "out_valid after reset", int'(out_valid), 0);
    endtask

    task automatic t_grouped();   // R3 with R2/R6
        for (int i = 0; i < N; i++) begin
            ped[i] = 100 + i;
            raw[i] = ped[i] + (i / 32) * 50 - 60 + (i % 7);
        end
        load_peds();
        model(0);
        run_frame("R3", 0, 0, 0);
    endtask

    task automatic t_trunc();     // R4 with outliers, under backpressure
        for (int i = 0; i < N; i++) begin
            ped[i] = 200 - (i % 9);
            raw[i] = ped[i] + 20 + (i % 5);
        end
        for (int i = 0; i < 10; i++) raw[i * 11 + 3] = 1000;
        for (int i = 0; i < 16; i++) raw[i * 7 + 5] = 0;
        load_peds();
        model(1);
        run_frame("R4", 1, 1, 1);
    endtask

    task automatic t_median();    // R5 with codes 2 and 3
        for (int i = 0; i < N; i++) begin
            ped[i] = 50 + (i % 4);
            raw[i] = 300 + ((i * 37) % 128) * 3;
        end
        load_peds();
        model(2);
        run_frame("R5", 2, 2, 0);
        for (int i = 0; i < N; i++) raw[i] = 900 - ((i * 53) % 128) * 5;
        model(3);
        run_frame("R5", 3, 3, 1);
    endtask

    task automatic t_saturate();  // R2 and R6 clamping
        for (int i = 0; i < N; i++) begin
            ped[i] = (i % 2 == 0) ? -1000 : 1000;
            raw[i] = (i % 2 == 0) ? 1023 : 0;
        end
        load_peds();
        model(2);
        check("R2", "model clamps pedestal step", sat(raw[0] - ped[0]), 1023);
        run_frame("R2", 2, 2, 0);
        check("R6", "clamped corrected even strip", expv[0], 1023);
    endtask

    task automatic t_mode_switch();  // R7
        for (int i = 0; i < N; i++) begin
            ped[i] = 10;
            raw[i] = 400 + (i / 32) * 100 + (i % 13) * 4;
        end
        load_peds();
        model(0);
        run_frame("R7", 0, 2, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_grouped();
        t_trunc();
        t_median();
        t_saturate();
        t_mode_switch();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule